// File: doc/BRIEF.md
# Unit-Relative Register Address Translator

This block turns a register address written for the zeroth instance of an on-chip unit into the real address of one particular instance. A requester presents a unit-type code, a small instance number and a 64-bit address together with a one-cycle strobe. One clock later the block presents the rewritten address and a flag that marks unit types it does not support.

Each supported unit type rewrites a different set of address fields using its own arithmetic on the instance number. The fields are the chiplet id (bits 29:24), the ring (bits 13:10), the satellite id (bits 9:6), the satellite offset (bits 5:0) and the receive/transmit group (bits 47:40). Some types pick a sub-case from the incoming chiplet id or ring. Every field result wraps within that field's width. The satellite offset is carried through unchanged by every type listed here. The chiplet-id and ring constants are module parameters; the values below are the defaults.

Top module: `unit_addr_xlate`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and carries that request's result. When `in_valid` is low, `out_valid` goes low after the edge and `out_addr` and `out_err` hold their values.
- R2: Type codes 0 (whole chip) and 1 (memory buffer) return the address unchanged, with `out_err` low.
- R3: Type codes 6 to 15 set `out_err` and return the address unchanged. Codes 0 to 5 clear `out_err`.
- R4: Type 2 (core pair) with an incoming chiplet id in 0x10..0x15 sets the chiplet id to 0x10 + inst/2. It also replaces ring bit 0 with inst mod 2.
- R5: Type 2 with an incoming chiplet id in 0x20..0x37 sets the chiplet id to 0x20 + (incoming chiplet mod 2) + 2*inst.
- R6: Type 3 (host bridge) computes a base of 1 when the incoming satellite id is below 4, and 4 otherwise. Instance 0 takes that base as its satellite id. It also sets the ring to 6 when the chiplet id is 0x04, and otherwise sets the chiplet id to 0x0D.
- R7: Type 3 with instance n > 0 sets the satellite id to base + (1 if n is even) + (2n)/5. The ring (chiplet 0x04) or chiplet id (other chiplets) becomes its instance-0 value plus n/3 + 1.
- R8: Type 4 (memory channel) with chiplet id 0x07 or 0x08 and ring 2 sets the chiplet id to 0x07 + inst/4. The satellite id keeps its upper two bits and takes inst mod 4 in its lower two bits.
- R9: Type 4 with chiplet id 0x07 or 0x08 and ring 4 sets the chiplet id to 0x07 + inst/4. The group field keeps its upper nibble, and its lower nibble becomes 3, 2, 0 or 1 for inst mod 4 = 0, 1, 2 or 3.
- R10: Type 5 (memory port) masks the address with 0xFFFFFFFF7FFFFC00. When the result equals 0x03010400 and inst is 1, bit 11 is set. When the result equals 0x03010800, inst*0x840 is ORed into the address. Any other address is unchanged.
- R11: Address bits 63:48 and 39:30 always pass through. A supported type whose sub-case conditions are not met returns the address unchanged. Field arithmetic wraps within the field's width.
- R12: During reset, `out_valid`, `out_addr` and `out_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_type | input | 4 | Unit-type code |
| in_inst | input | 4 | Instance number |
| in_addr | input | 64 | Address relative to instance zero |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 64 | Translated address |
| out_err | output | 1 | Unsupported unit type |

## Verification
The same clock edge can retire one result and load the next. When an unsupported type follows a supported one on consecutive strobes, the error flag must rise and the address must update at that edge, with nothing left over from the previous request. The bench provokes this with back-to-back strobes that mix types, and with idle gaps placed between some of them. A behavioural model compares the strobe, address and flag on every clock, so a stale or early update shows up in the cycle where it happens.

// File: rtl/unit_addr_xlate_pkg.sv
package unit_addr_xlate_pkg;

    localparam int ADDR_W   = 64;
    localparam int INST_W   = 4;
    localparam int TYPE_W   = 4;

    localparam int CHIP_LSB = 24;
    localparam int CHIP_W   = 6;
    localparam int RING_LSB = 10;
    localparam int RING_W   = 4;
    localparam int SAT_LSB  = 6;
    localparam int SAT_W    = 4;
    localparam int GRP_LSB  = 40;
    localparam int GRP_W    = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [INST_W-1:0] inst_t;
    typedef logic [CHIP_W-1:0] chip_t;
    typedef logic [RING_W-1:0] ring_t;
    typedef logic [SAT_W-1:0]  sat_t;
    typedef logic [GRP_W-1:0]  grp_t;

    typedef enum logic [TYPE_W-1:0] {
        UT_CHIP     = 4'd0,
        UT_BUFFER   = 4'd1,
        UT_COREPAIR = 4'd2,
        UT_HOSTBR   = 4'd3,
        UT_MEMCHAN  = 4'd4,
        UT_MEMPORT  = 4'd5
    } unit_e;

    typedef struct packed {
        addr_t addr;
        logic  err;
    } xlate_res_t;

    localparam addr_t PORT_MASK       = 64'hFFFF_FFFF_7FFF_FC00;
    localparam addr_t PORT_BASE       = 64'h0000_0000_0301_0400;
    localparam addr_t PORT_TRACE_BASE = 64'h0000_0000_0301_0800;
    localparam addr_t PORT_HI_BIT     = 64'h0000_0000_0000_0800;
    localparam addr_t PORT_TRACE_STEP = 64'h0000_0000_0000_0840;

    function automatic chip_t get_chip(addr_t a);
        return a[CHIP_LSB +: CHIP_W];
    endfunction

    function automatic ring_t get_ring(addr_t a);
        return a[RING_LSB +: RING_W];
    endfunction

    function automatic sat_t get_sat(addr_t a);
        return a[SAT_LSB +: SAT_W];
    endfunction

    function automatic grp_t get_grp(addr_t a);
        return a[GRP_LSB +: GRP_W];
    endfunction

    function automatic addr_t set_chip(addr_t a, chip_t v);
        addr_t r;
        r = a;
        r[CHIP_LSB +: CHIP_W] = v;
        return r;
    endfunction

    function automatic addr_t set_ring(addr_t a, ring_t v);
        addr_t r;
        r = a;
        r[RING_LSB +: RING_W] = v;
        return r;
    endfunction

    function automatic addr_t set_sat(addr_t a, sat_t v);
        addr_t r;
        r = a;
        r[SAT_LSB +: SAT_W] = v;
        return r;
    endfunction

    function automatic addr_t set_grp(addr_t a, grp_t v);
        addr_t r;
        r = a;
        r[GRP_LSB +: GRP_W] = v;
        return r;
    endfunction

    // Lane reorder for the IO-ring group field of the memory channel.
    function automatic grp_t grp_lane(logic [1:0] q);
        case (q)
            2'd0:    return grp_t'(3);
            2'd1:    return grp_t'(2);
            2'd2:    return grp_t'(0);
            default: return grp_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/axl_corepair.sv
module axl_corepair
    import unit_addr_xlate_pkg::*;
#(
    parameter int CACHE_FIRST = 16,
    parameter int CACHE_LAST  = 21,
    parameter int CORE_FIRST  = 32,
    parameter int CORE_LAST   = 55
) (
    input  addr_t addr_i,
    input  inst_t inst_i,
    output addr_t addr_o
);
    chip_t chip;
    ring_t ring;

    always_comb begin
        chip   = get_chip(addr_i);
        ring   = get_ring(addr_i);
        addr_o = addr_i;
        if (int'(chip) >= CACHE_FIRST && int'(chip) <= CACHE_LAST) begin
            addr_o = set_chip(addr_o, chip_t'(CACHE_FIRST + int'(inst_i >> 1)));
            addr_o = set_ring(addr_o, (ring & ~ring_t'(1)) | ring_t'(inst_i[0]));
        end else if (int'(chip) >= CORE_FIRST && int'(chip) <= CORE_LAST) begin
            addr_o = set_chip(addr_o,
                     chip_t'(CORE_FIRST + int'(chip[0]) + 2 * int'(inst_i)));
        end
    end
endmodule

// File: rtl/axl_hostbridge.sv
module axl_hostbridge
    import unit_addr_xlate_pkg::*;
#(
    parameter int NEST_CHIPLET = 4,
    parameter int PCI_FIRST    = 13,
    parameter int RING_FIRST   = 6
) (
    input  addr_t addr_i,
    input  inst_t inst_i,
    output addr_t addr_o
);
    int base;
    int step;
    int sat_new;

    always_comb begin
        base = (get_sat(addr_i) < sat_t'(4)) ? 1 : 4;
        if (inst_i == '0) begin
            step    = 0;
            sat_new = base;
        end else begin
            step    = int'(inst_i) / 3 + 1;
            sat_new = base + (inst_i[0] ? 0 : 1) + (2 * int'(inst_i)) / 5;
        end
        addr_o = set_sat(addr_i, sat_t'(sat_new));
        if (int'(get_chip(addr_i)) == NEST_CHIPLET)
            addr_o = set_ring(addr_o, ring_t'(RING_FIRST + step));
        else
            addr_o = set_chip(addr_o, chip_t'(PCI_FIRST + step));
    end
endmodule

// File: rtl/axl_memchan.sv
module axl_memchan
    import unit_addr_xlate_pkg::*;
#(
    parameter int MEM_FIRST = 7,
    parameter int CHAN_RING = 2,
    parameter int IO_RING   = 4
) (
    input  addr_t addr_i,
    input  inst_t inst_i,
    output addr_t addr_o
);
    localparam int MEM_LAST = MEM_FIRST + 1;

    chip_t chip;
    ring_t ring;
    chip_t chip_new;

    always_comb begin
        chip     = get_chip(addr_i);
        ring     = get_ring(addr_i);
        chip_new = chip_t'(MEM_FIRST + int'(inst_i >> 2));
        addr_o   = addr_i;
        if (int'(chip) >= MEM_FIRST && int'(chip) <= MEM_LAST) begin
            if (int'(ring) == CHAN_RING) begin
                addr_o = set_chip(addr_o, chip_new);
                addr_o = set_sat(addr_o,
                         (get_sat(addr_i) & ~sat_t'(3)) | sat_t'(inst_i[1:0]));
            end else if (int'(ring) == IO_RING) begin
                addr_o = set_chip(addr_o, chip_new);
                addr_o = set_grp(addr_o,
                         (get_grp(addr_i) & grp_t'(8'hF0)) + grp_lane(inst_i[1:0]));
            end
        end
    end
endmodule

// File: rtl/axl_memport.sv
module axl_memport
    import unit_addr_xlate_pkg::*;
(
    input  addr_t addr_i,
    input  inst_t inst_i,
    output addr_t addr_o
);
    addr_t masked;

    always_comb begin
        masked = addr_i & PORT_MASK;
        addr_o = addr_i;
        if (masked == PORT_BASE) begin
            if (inst_i == inst_t'(1))
                addr_o = addr_i | PORT_HI_BIT;
        end else if (masked == PORT_TRACE_BASE) begin
            addr_o = addr_i | (PORT_TRACE_STEP * addr_t'(inst_i));
        end
    end
endmodule

// File: rtl/unit_addr_xlate.sv
module unit_addr_xlate
    import unit_addr_xlate_pkg::*;
#(
    parameter int CACHE_FIRST  = 16,
    parameter int CACHE_LAST   = 21,
    parameter int CORE_FIRST   = 32,
    parameter int CORE_LAST    = 55,
    parameter int NEST_CHIPLET = 4,
    parameter int PCI_FIRST    = 13,
    parameter int HB_RING      = 6,
    parameter int MEM_FIRST    = 7,
    parameter int CHAN_RING    = 2,
    parameter int IO_RING      = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  in_type,
    input  logic [3:0]  in_inst,
    input  logic [63:0] in_addr,
    output logic        out_valid,
    output logic [63:0] out_addr,
    output logic        out_err
);
    addr_t      cp_addr;
    addr_t      hb_addr;
    addr_t      mc_addr;
    addr_t      mp_addr;
    xlate_res_t nxt;

    axl_corepair #(
        .CACHE_FIRST(CACHE_FIRST), .CACHE_LAST(CACHE_LAST),
        .CORE_FIRST(CORE_FIRST),   .CORE_LAST(CORE_LAST)
    ) corepair_i (.addr_i(in_addr), .inst_i(in_inst), .addr_o(cp_addr));

    axl_hostbridge #(
        .NEST_CHIPLET(NEST_CHIPLET), .PCI_FIRST(PCI_FIRST), .RING_FIRST(HB_RING)
    ) hostbridge_i (.addr_i(in_addr), .inst_i(in_inst), .addr_o(hb_addr));

    axl_memchan #(
        .MEM_FIRST(MEM_FIRST), .CHAN_RING(CHAN_RING), .IO_RING(IO_RING)
    ) memchan_i (.addr_i(in_addr), .inst_i(in_inst), .addr_o(mc_addr));

    axl_memport memport_i (.addr_i(in_addr), .inst_i(in_inst), .addr_o(mp_addr));

    always_comb begin
        nxt.addr = in_addr;
        nxt.err  = 1'b0;
        case (in_type)
            UT_CHIP, UT_BUFFER: nxt.addr = in_addr;
            UT_COREPAIR:        nxt.addr = cp_addr;
            UT_HOSTBR:          nxt.addr = hb_addr;
            UT_MEMCHAN:         nxt.addr = mc_addr;
            UT_MEMPORT:         nxt.addr = mp_addr;
            default:            nxt.err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= nxt.addr;
                out_err  <= nxt.err;
            end
        end
    end
endmodule

// File: rtl/unit_addr_xlate_chk.sv
module unit_addr_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  in_type,
    input logic [63:0] in_addr,
    input logic        out_valid,
    input logic [63:0] out_addr,
    input logic        out_err
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_addr) && $stable(out_err)));

    a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type <= 4'd1) |=> (out_addr == $past(in_addr) && !out_err));

    a_r3_unknown_err: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type > 4'd5) |=> (out_err && out_addr == $past(in_addr)));

    a_r3_known_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type <= 4'd5) |=> !out_err);

    a_r11_outer_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_addr[63:48] == $past(in_addr[63:48]) &&
                      out_addr[39:30] == $past(in_addr[39:30])));

    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && out_addr == 64'd0));
endmodule

bind unit_addr_xlate unit_addr_xlate_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
);

// File: tb/unit_addr_xlate_tb_top.sv
`timescale 1ns/1ps
module unit_addr_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_type = '0;
    logic [3:0]  in_inst = '0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    string cur_tag = "R1";
    string m_tag = "R1";
    logic        m_valid = 1'b0;
    logic [63:0] m_addr = '0;
    logic        m_err = 1'b0;

    always #4 clk = ~clk;

    unit_addr_xlate dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type),
        .in_inst(in_inst), .in_addr(in_addr), .out_valid(out_valid),
        .out_addr(out_addr), .out_err(out_err)
    );

    function automatic logic [64:0] ref_xlate(int t, int n, logic [63:0] a);
        logic [63:0] r;
        int chip, ring, sat, grp, b, adj;
        r = a;
        chip = int'(a[29:24]); ring = int'(a[13:10]);
        sat  = int'(a[9:6]);   grp  = int'(a[47:40]);
        case (t)
            0, 1: ;
            2: begin
                if (chip >= 16 && chip <= 21) begin
                    r[29:24] = 6'(16 + n / 2);
                    r[13:10] = 4'((ring / 2) * 2 + n % 2);
                end else if (chip >= 32 && chip <= 55) begin
                    r[29:24] = 6'(32 + chip % 2 + 2 * n);
                end
            end
            3: begin
                b = (sat < 4) ? 1 : 4;
                if (n > 0) b = b + ((n % 2 == 0) ? 1 : 0) + (2 * n) / 5;
                r[9:6] = 4'(b);
                if (chip == 4) r[13:10] = 4'(6 + ((n == 0) ? 0 : n / 3 + 1));
                else           r[29:24] = 6'(13 + ((n == 0) ? 0 : n / 3 + 1));
            end
            4: begin
                if (chip == 7 || chip == 8) begin
                    if (ring == 2) begin
                        r[29:24] = 6'(7 + n / 4);
                        r[9:6]   = 4'((sat / 4) * 4 + n % 4);
                    end else if (ring == 4) begin
                        adj = (n % 4 == 0) ? 3 : (n % 4 == 1) ? 2 : (n % 4 == 2) ? 0 : 1;
                        r[29:24] = 6'(7 + n / 4);
                        r[47:40] = 8'((grp / 16) * 16 + adj);
                    end
                end
            end
            5: begin
                if ((a & 64'hFFFF_FFFF_7FFF_FC00) == 64'h0301_0400) begin
                    if (n == 1) r = a | 64'h800;
                end else if ((a & 64'hFFFF_FFFF_7FFF_FC00) == 64'h0301_0800) begin
                    r = a | (64'h840 * 64'(n));
                end
            end
            default: return {1'b1, a};
        endcase
        return {1'b0, r};
    endfunction

    function automatic logic [63:0] mk(int chip, int ring, int sat, int off, int grp,
                                       logic [63:0] hi);
        logic [63:0] a;
        a = hi;
        a[29:24] = 6'(chip); a[13:10] = 4'(ring); a[9:6] = 4'(sat);
        a[5:0] = 6'(off);    a[47:40] = 8'(grp);
        return a;
    endfunction

    always @(posedge clk) begin
        logic [64:0] r;
        if (rst) begin
            m_valid <= 1'b0; m_addr <= '0; m_err <= 1'b0;
        end else begin
            m_valid <= in_valid;
            m_tag   <= in_valid ? cur_tag : "R1";
            if (in_valid) begin
                r = ref_xlate(int'(in_type), int'(in_inst), in_addr);
                m_addr <= r[63:0];
                m_err  <= r[64];
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (out_valid !== m_valid || out_addr !== m_addr || out_err !== m_err) begin
                errors++;
                $display("FAIL %s: valid/addr/err actual %0b/%h/%0b expected %0b/%h/%0b",
                         m_tag, out_valid, out_addr, out_err, m_valid, m_addr, m_err);
            end
        end
    end

    task automatic send(int t, int n, logic [63:0] a, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_type = 4'(t); in_inst = 4'(n); in_addr = a; cur_tag = tag;
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_addr = 64'hDEAD_BEEF_0BAD_F00D; in_type = 4'd2;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid !== 1'b0 || out_addr !== 64'd0 || out_err !== 1'b0) begin
            errors++;
            $display("FAIL R12: actual %0b/%h/%0b expected 0/0/0", out_valid, out_addr, out_err);
        end
        rst = 1'b0;
        cmp_on = 1'b1;

        send(0, 5, 64'h1234_5678_9ABC_DEF0, "R2");
        send(1, 9, 64'hFFFF_0000_FFFF_0000, "R2");
        send(6, 0, 64'h0000_1111_2222_3333, "R3");
        send(2, 3, mk(18, 5, 3, 7, 0, 64'h0), "R3");
        send(15, 2, 64'hA5A5_A5A5_A5A5_A5A5, "R3");
        idle(2);
        send(2, 3, mk(18, 5, 3, 7, 0, 64'h0), "R4");
        send(2, 4, mk(16, 7, 1, 1, 0, 64'h0), "R4");
        send(2, 11, mk(21, 0, 2, 2, 0, 64'h0), "R4");
        send(2, 2, mk(37, 1, 0, 0, 0, 64'h0), "R5");
        send(2, 15, mk(32, 3, 0, 0, 0, 64'h0), "R5");
        send(2, 6, mk(55, 9, 0, 0, 0, 64'h0), "R5");
        send(3, 0, mk(4, 0, 2, 5, 0, 64'h0), "R6");
        send(3, 0, mk(13, 1, 7, 5, 0, 64'h0), "R6");
        for (int n = 1; n < 16; n++) begin
            send(3, n, mk(4, 3, 1, 9, 0, 64'h0), "R7");
            send(3, n, mk(13, 3, 9, 9, 0, 64'h0), "R7");
        end
        for (int n = 0; n < 8; n++) begin
            send(4, n, mk(7 + n % 2, 2, 13, 4, 0, 64'h0), "R8");
            send(4, n, mk(8 - n % 2, 4, 0, 4, 8'hA7, 64'h0), "R9");
        end
        send(5, 1, 64'h0301_0400, "R10");
        send(5, 0, 64'h0301_0400, "R10");
        send(5, 1, 64'h8000_0000_0301_05FF, "R10");
        send(5, 3, 64'h0301_0800, "R10");
        send(5, 1, 64'h0301_0880, "R10");
        send(5, 2, 64'h0302_0400, "R10");
        idle(1);
        send(2, 5, mk(40 - 20, 6, 0, 0, 0, 64'h0), "R11");
        send(2, 5, mk(5, 6, 0, 0, 0, 64'hFFFF_0000_C000_0000), "R11");
        send(4, 5, mk(7, 9, 3, 0, 0, 64'h0), "R11");
        send(4, 5, mk(9, 2, 3, 0, 0, 64'h0), "R11");
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if (i % 3 == 0) a[29:24] = 6'($urandom_range(0, 60));
            if (i % 4 == 0) a[13:10] = 4'($urandom_range(0, 5));
            if (i % 7 == 0) begin
                send(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), a, "R11");
                idle(int'($urandom_range(1, 2)));
            end else begin
                send(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), a, "R11");
            end
        end
        idle(3);
        @(negedge clk);
        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule